// File: doc/BRIEF.md
# Platform Device Enumeration Controller

A register-mapped slave through which a host discovers the devices built into a system. It holds a table of device descriptors fixed at elaboration time. For each entry the table gives an identifier, a name length, an I/O window (base and size), a first interrupt line and an interrupt count. The host walks the table with a cursor that it steps by reading the operation register. Each device is reported once per enumeration pass. A single level interrupt stays high while the current pass still has devices that have not been reported.

The host starts a pass by writing zero to the operation register. It then reads that register repeatedly. Each read that returns "add device" leaves the cursor on a new entry, and the host reads that entry's fields from the descriptor registers. A read that returns "done" ends the pass and drops the interrupt. Name strings are not moved by the block. Only their length is visible.

Top module: `pdx_enum_ctrl`

## Requirements
- R1: After reset, `irq` and `rdata` are 0 and the error flag is clear. The cursor is "none" and no device is marked reported, so the first operation read returns 0x08 and selects entry 0. `irq` stays low until the first init write.
- R2: A write of 0 to offset 0x00 (init) clears every reported flag, sets the cursor to "none" and clears the error flag. It raises `irq`, which then stays high until an operation read finds no device.
- R3: A read of offset 0x00 behaves in two ways. With a valid cursor, it marks that entry reported and searches from the next index. With cursor "none", it searches from index 0. The search skips reported entries. When it finds one, the cursor moves there and the read returns 0x08.
- R4: When an operation read finds no unreported entry, it returns 0x00, sets the cursor to "none" and drops `irq`. Any later operation read before an init also returns 0x00.
- R5: The descriptor reads return the field of the cursor entry, or 0 when the cursor is "none". The offsets are 0x08 name length, 0x0C identifier, 0x10 I/O base, 0x14 I/O size, 0x18 first interrupt and 0x1C interrupt count.
- R6: The fields of entry i are fixed by formula. Identifier = 0x100+i. Name length = 3+i. Size = 0x1000 << (i mod 4). Interrupt count = 1+(i mod 2). Base = IO_BASE0 plus the sizes of all earlier entries. First interrupt = IRQ_BASE0 plus the counts of all earlier entries.
- R7: A write to offset 0x04 changes nothing: not the cursor, not the reported flags, not the error flag.
- R8: The error flag is set by any of these: a nonzero write to 0x00, a write to any offset other than 0x00 or 0x04, or a read of any offset other than 0x00 and 0x08–0x20. Such reads return 0. Bit 0 of offset 0x20 shows the flag, and only an init write clears it.
- R9: `rdata` is registered. It is updated on the edge that samples a read strobe and holds between reads. A read's side effects occur on that same edge. When `rd_en` and `wr_en` are both high, only the write takes effect.
- R10: An operation read never returns the remove-device code 0x04. Its only results are 0x00 and 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: devices remain in this pass |

## Verification
Most internal faults show up on the next operation or descriptor read. A wrong reported flag or cursor returns the wrong entry's fields, or ends the pass with "done" too early or too late. A stuck interrupt level is visible the cycle after the init write or the final operation read. A lost error flag appears on the next read of offset 0x20. The reference model in the bench tracks its own flags and cursor and compares `rdata` and `irq` on every cycle, so a divergence is reported in the cycle it appears.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

    localparam int REG_OP    = 'h00;
    localparam int REG_NAME  = 'h04;
    localparam int REG_NLEN  = 'h08;
    localparam int REG_ID    = 'h0C;
    localparam int REG_BASE  = 'h10;
    localparam int REG_SIZE  = 'h14;
    localparam int REG_IRQ   = 'h18;
    localparam int REG_ICNT  = 'h1C;
    localparam int REG_ERR   = 'h20;

    localparam logic [31:0] CODE_DONE = 32'h0000_0000;
    localparam logic [31:0] CODE_ADD  = 32'h0000_0008;

    typedef struct packed {
        logic [31:0] id;
        logic [31:0] name_len;
        logic [31:0] io_base;
        logic [31:0] io_size;
        logic [31:0] irq_first;
        logic [31:0] irq_cnt;
    } desc_t;

    typedef enum logic [3:0] {
        SEL_OP, SEL_NLEN, SEL_ID, SEL_BASE, SEL_SIZE,
        SEL_IRQ, SEL_ICNT, SEL_ERR, SEL_NONE
    } rd_sel_e;

    function automatic logic [31:0] slot_size(int k);
        return 32'h1000 << (k % 4);
    endfunction

    function automatic logic [31:0] slot_irqs(int k);
        return 32'(1 + (k % 2));
    endfunction

    function automatic desc_t make_desc(int idx, logic [31:0] base0, logic [31:0] irq0);
        desc_t d;
        logic [31:0] b;
        logic [31:0] q;
        b = base0;
        q = irq0;
        for (int k = 0; k < idx; k++) begin
            b = b + slot_size(k);
            q = q + slot_irqs(k);
        end
        d.id        = 32'h100 + 32'(idx);
        d.name_len  = 32'(3 + idx);
        d.io_base   = b;
        d.io_size   = slot_size(idx);
        d.irq_first = q;
        d.irq_cnt   = slot_irqs(idx);
        return d;
    endfunction

endpackage

// File: rtl/pdx_desc_table.sv
module pdx_desc_table
    import pdx_pkg::*;
#(
    parameter int          NUM_DEV   = 5,
    parameter logic [31:0] IO_BASE0  = 32'h1000_0000,
    parameter logic [31:0] IRQ_BASE0 = 32'd2,
    localparam int         IDX_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic [IDX_W-1:0] sel_idx,
    output desc_t            sel_desc
);

    desc_t entries [NUM_DEV];

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_entry
        assign entries[g] = make_desc(g, IO_BASE0, IRQ_BASE0);
    end

    assign sel_desc = entries[sel_idx];

endmodule

// File: rtl/pdx_cursor.sv
module pdx_cursor #(
    parameter int  NUM_DEV = 5,
    localparam int IDX_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             advance,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_valid,
    output logic             nxt_found
);

    logic [NUM_DEV-1:0] rep_q;
    logic [NUM_DEV-1:0] rep_upd;
    logic [IDX_W-1:0]   nxt_idx;
    int                 start_i;

    always_comb begin
        rep_upd = rep_q;
        start_i = 0;
        if (cur_valid) begin
            rep_upd[cur_idx] = 1'b1;
            start_i = int'(cur_idx) + 1;
        end
        nxt_found = 1'b0;
        nxt_idx   = '0;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (i >= start_i && !rep_upd[i]) begin
                nxt_found = 1'b1;
                nxt_idx   = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            rep_q     <= '0;
            cur_valid <= 1'b0;
            cur_idx   <= '0;
        end else if (advance) begin
            rep_q     <= rep_upd;
            cur_valid <= nxt_found;
            cur_idx   <= nxt_found ? nxt_idx : '0;
        end
    end

    // R3: the cursor never rests on an entry already reported
    a_r3_cursor_unreported: assert property (@(posedge clk) disable iff (rst)
        cur_valid |-> !rep_q[cur_idx]);

    // R3: reported flags only accumulate within a pass
    a_r3_flags_monotone: assert property (@(posedge clk) disable iff (rst)
        !$past(init) |-> $countones(rep_q) >= $past($countones(rep_q)));

    // R7: without a step or an init the flags hold
    a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(advance) && !$past(init)) |-> $stable(rep_q));

endmodule

// File: rtl/pdx_decode.sv
module pdx_decode
    import pdx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              init_wr,
    output logic              op_rd,
    output logic              rd_act,
    output logic              bad_acc,
    output rd_sel_e           rd_sel
);

    always_comb begin
        init_wr = 1'b0;
        op_rd   = 1'b0;
        bad_acc = 1'b0;
        rd_sel  = SEL_NONE;
        rd_act  = rd_en && !wr_en;
        if (wr_en) begin
            if (addr == ADDR_W'(REG_OP)) begin
                if (wdata == 32'd0) init_wr = 1'b1;
                else                bad_acc = 1'b1;
            end else if (addr != ADDR_W'(REG_NAME)) begin
                bad_acc = 1'b1;
            end
        end else if (rd_en) begin
            case (addr)
                ADDR_W'(REG_OP):   begin rd_sel = SEL_OP; op_rd = 1'b1; end
                ADDR_W'(REG_NLEN): rd_sel = SEL_NLEN;
                ADDR_W'(REG_ID):   rd_sel = SEL_ID;
                ADDR_W'(REG_BASE): rd_sel = SEL_BASE;
                ADDR_W'(REG_SIZE): rd_sel = SEL_SIZE;
                ADDR_W'(REG_IRQ):  rd_sel = SEL_IRQ;
                ADDR_W'(REG_ICNT): rd_sel = SEL_ICNT;
                ADDR_W'(REG_ERR):  rd_sel = SEL_ERR;
                default:           bad_acc = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pdx_enum_ctrl.sv
module pdx_enum_ctrl
    import pdx_pkg::*;
#(
    parameter int          NUM_DEV   = 5,
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] IO_BASE0  = 32'h1000_0000,
    parameter logic [31:0] IRQ_BASE0 = 32'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);

    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic             init_wr, op_rd, rd_act, bad_acc;
    rd_sel_e          rd_sel;
    logic [IDX_W-1:0] cur_idx;
    logic             cur_valid, nxt_found;
    desc_t            cur_desc;
    logic             err_q;
    logic [31:0]      rd_next;

    pdx_decode #(.ADDR_W(ADDR_W)) u_dec (
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .init_wr(init_wr), .op_rd(op_rd), .rd_act(rd_act),
        .bad_acc(bad_acc), .rd_sel(rd_sel)
    );

    pdx_cursor #(.NUM_DEV(NUM_DEV)) u_cur (
        .clk(clk), .rst(rst), .init(init_wr), .advance(op_rd),
        .cur_idx(cur_idx), .cur_valid(cur_valid), .nxt_found(nxt_found)
    );

    pdx_desc_table #(.NUM_DEV(NUM_DEV), .IO_BASE0(IO_BASE0), .IRQ_BASE0(IRQ_BASE0)) u_tab (
        .sel_idx(cur_idx), .sel_desc(cur_desc)
    );

    always_comb begin
        rd_next = 32'd0;
        case (rd_sel)
            SEL_OP:   rd_next = nxt_found ? CODE_ADD : CODE_DONE;
            SEL_NLEN: rd_next = cur_valid ? cur_desc.name_len  : 32'd0;
            SEL_ID:   rd_next = cur_valid ? cur_desc.id        : 32'd0;
            SEL_BASE: rd_next = cur_valid ? cur_desc.io_base   : 32'd0;
            SEL_SIZE: rd_next = cur_valid ? cur_desc.io_size   : 32'd0;
            SEL_IRQ:  rd_next = cur_valid ? cur_desc.irq_first : 32'd0;
            SEL_ICNT: rd_next = cur_valid ? cur_desc.irq_cnt   : 32'd0;
            SEL_ERR:  rd_next = {31'd0, err_q};
            default:  rd_next = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= 32'd0;
            irq   <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (rd_act) rdata <= rd_next;
            if (init_wr)                 irq <= (NUM_DEV > 0);
            else if (op_rd && !nxt_found) irq <= 1'b0;
            if (init_wr)      err_q <= 1'b0;
            else if (bad_acc) err_q <= 1'b1;
        end
    end

    // R2: the interrupt rises only after an init write
    a_r2_irq_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(wr_en) && $past(addr) == ADDR_W'(REG_OP) && $past(wdata) == 32'd0);

    // R4: the interrupt falls only after an operation read
    a_r4_irq_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(rd_en) && !$past(wr_en) && $past(addr) == ADDR_W'(REG_OP));

    // R8: the error flag clears only on init
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(err_q) |-> $past(wr_en) && $past(wdata) == 32'd0);

    // R10: an operation read yields only done or add
    a_r10_op_codes: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && !$past(wr_en) && $past(addr) == ADDR_W'(REG_OP))
            |-> (rdata == CODE_DONE || rdata == CODE_ADD));

    // R9: read data holds when no read is performed
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(rdata));

endmodule

// File: tb/sim_pdx_enum_ctrl.sv
module sim_pdx_enum_ctrl;

    localparam int          NDEV  = 5;
    localparam int          AW    = 8;
    localparam logic [31:0] BASE0 = 32'h1000_0000;
    localparam logic [31:0] IRQ0  = 32'd2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    // reference model state
    bit          rep [NDEV];
    int          cur = -1;
    bit          irq_m = 1'b0;
    bit          err_m = 1'b0;
    logic [31:0] rd_m = '0;

    always #2 clk = ~clk;

    pdx_enum_ctrl #(.NUM_DEV(NDEV), .ADDR_W(AW), .IO_BASE0(BASE0), .IRQ_BASE0(IRQ0)) u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] f_size(int i);
        return 32'h1000 << (i % 4);
    endfunction
    function automatic logic [31:0] f_cnt(int i);
        return 32'(1 + (i % 2));
    endfunction
    function automatic logic [31:0] field(int i, int off);
        logic [31:0] b = BASE0;
        logic [31:0] q = IRQ0;
        for (int k = 0; k < i; k++) begin
            b += f_size(k);
            q += f_cnt(k);
        end
        case (off)
            'h08: return 32'(3 + i);
            'h0C: return 32'h100 + 32'(i);
            'h10: return b;
            'h14: return f_size(i);
            'h18: return q;
            default: return f_cnt(i);
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (rep[i]) rep[i] = 1'b0;
            cur = -1; irq_m = 1'b0; err_m = 1'b0; rd_m = '0;
        end else if (wr_en) begin
            if (addr == 0 && wdata == 0) begin
                foreach (rep[i]) rep[i] = 1'b0;
                cur = -1; irq_m = 1'b1; err_m = 1'b0;
            end else if (addr != 8'h04) begin
                err_m = 1'b1;
            end
        end else if (rd_en) begin
            if (addr == 0) begin
                int s;
                s = 0;
                if (cur >= 0) begin rep[cur] = 1'b1; s = cur + 1; end
                cur = -1;
                for (int i = s; i < NDEV; i++)
                    if (cur < 0 && !rep[i]) cur = i;
                if (cur >= 0) rd_m = 32'h8;
                else begin rd_m = 32'h0; irq_m = 1'b0; end
            end else if (addr >= 8'h08 && addr <= 8'h1C && addr[1:0] == 2'b00) begin
                rd_m = (cur < 0) ? 32'h0 : field(cur, int'(addr));
            end else if (addr == 8'h20) begin
                rd_m = {31'd0, err_m};
            end else begin
                rd_m = 32'h0; err_m = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (rdata !== rd_m) begin
                fails++;
                $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, rd_m);
            end
            checks++;
            if (irq !== irq_m) begin
                fails++;
                $display("FAIL %s irq actual=%b expected=%b", tag, irq, irq_m);
            end
        end
    end

    task automatic rd(input int a);
        @(negedge clk); rd_en = 1'b1; addr = AW'(a);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic read_desc();
        for (int o = 'h08; o <= 'h1C; o += 4) rd(o);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired in %s", tag);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        repeat (2) @(negedge clk);
        rd('h20);
        read_desc();
        rd('h00);            // entry 0 found, irq still low
        rd('h0C);

        tag = "R2"; wr('h00, 0);
        tag = "R5"; read_desc();
        tag = "R3";
        for (int n = 0; n < NDEV; n++) begin
            rd('h00);
            tag = "R6"; read_desc(); tag = "R3";
        end
        tag = "R4"; rd('h00); rd('h08); rd('h00); repeat (3) @(negedge clk);

        tag = "R2"; wr('h00, 0);
        tag = "R3"; rd('h00); rd('h00); rd('h0C);
        tag = "R7"; wr('h04, 32'hDEAD_BEEF); rd('h0C); rd('h20); rd('h00); rd('h0C);
        tag = "R2"; wr('h00, 0); rd('h00); rd('h0C);

        tag = "R8"; wr('h00, 5); rd('h20); rd('h00); rd('h0C);
        wr('h00, 0); rd('h20);
        rd('h24); rd('h20);
        wr('h00, 0); wr('h10, 1); rd('h20);
        wr('h00, 0); rd('h04); rd('h20);
        wr('h00, 0); rd('h0A); rd('h20);

        tag = "R9"; wr('h00, 0); rd('h00);
        @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; addr = 8'h00; wdata = 32'd0;
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
        rd('h0C); repeat (4) @(negedge clk);

        tag = "R10";
        wr('h00, 0);
        for (int n = 0; n < NDEV + 2; n++) rd('h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule